// File: doc/BRIEF.md
# Eight-Line Vectored Priority Interrupt Controller

This block gathers eight interrupt request lines into one interrupt output for a host processor. Each line is captured into a pending register, either on a rising edge or by following its level. A mask register keeps chosen lines from being forwarded. An in-service register records which interrupts the host has accepted but not yet finished. The interrupt output is raised only when a request would preempt every level that is already in service, so only higher priorities can nest.

When the host pulses the acknowledge input, the block picks the winning line and moves it from pending to in-service. One cycle later it presents a vector made of a programmable base joined with the line number. If the request has gone away before the acknowledge, the vector for line 7 is returned and nothing enters service. Priority is either fixed or rotating. The host ends an interrupt through a command write, or the block does it as part of the acknowledge when automatic mode is selected.

The vector leaves the block as a one-cycle valid pulse with no ready input, so there is no back-pressure: the host must take the vector in the cycle `vec_valid_o` is high. The register port accepts a write in every cycle it is strobed, and reads are combinational from the address.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the interrupt output and the vector valid are low, the mode register reads 0x00, the mask reads 0xFF, and the pending and in-service registers read 0x00.
- R2: In edge mode (mode bit 0 clear), a rising edge on a request line sets its pending bit one cycle later. The bit stays set after the line falls, until that line is acknowledged.
- R3: In level mode (mode bit 0 set), each pending bit equals the level its line had at the previous clock edge.
- R4: A line whose mask bit is 1 still shows in the pending register but never raises the interrupt output. Clearing the mask bit lets the request through.
- R5: The interrupt output is high exactly when some unmasked pending line has a higher priority than every line currently in service.
- R6: An acknowledge strobe is followed in the next cycle by a one-cycle `vec_valid_o` pulse. `vec_o` then carries the mode base (mode bits 7:3) in bits 7:3 and, in bits 2:0, the winning line: the highest-priority unmasked pending line that outranks the in-service set. That line's in-service bit is set, and in edge mode its pending bit is cleared.
- R7: In fixed priority mode (mode bit 2 clear), line 0 has the highest priority and line 7 the lowest.
- R8: A write to address 2 is a non-specific end of interrupt: it clears the highest-priority bit set in the in-service register.
- R9: In automatic end-of-interrupt mode (mode bit 1 set), an acknowledge sets no in-service bit.
- R10: In rotating mode (mode bit 2 set), the line whose interrupt ends, by command or automatically, becomes the lowest priority and the line after it the highest. Any mode write restores line 7 as the lowest.
- R11: An acknowledge with no qualifying request returns vector line 7 and leaves the in-service and pending registers unchanged.
- R12: Address 0 reads and writes the mode, address 1 the mask, address 2 reads pending, and address 3 reads in-service. A write to address 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 8 | Interrupt request lines 0..7 |
| int_o | output | 1 | Interrupt request to the host |
| ack_i | input | 1 | One-cycle acknowledge strobe from the host |
| vec_valid_o | output | 1 | Vector valid, one cycle after acknowledge |
| vec_o | output | 8 | Vector: base in bits 7:3, line in bits 2:0 |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for `cfg_addr` |

## Verification
A corrupt in-service register shows at the ports within one cycle. The interrupt output then either stays low while a higher request is pending, or rises for a request that should be blocked. The in-service readback at address 3 exposes the same error directly. A wrong rotation pointer stays hidden until two requests compete after an end of interrupt. It then shows as the wrong line number in the vector one cycle after the acknowledge. The bench therefore compares `int_o` and the vector against a reference model on every cycle, and it sets up competing requests after each rotation.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  // Register addresses of the host port
  typedef enum logic [1:0] {
    ADDR_MODE = 2'd0,
    ADDR_MASK = 2'd1,
    ADDR_CMD  = 2'd2,
    ADDR_ISR  = 2'd3
  } cfg_addr_e;

  // Flag positions in the mode register; the vector base fills the rest
  localparam int MODE_LEVEL_BIT = 0;
  localparam int MODE_AEOI_BIT  = 1;
  localparam int MODE_ROT_BIT   = 2;
  localparam int MODE_FLAG_BITS = 3;

endpackage

// File: rtl/irq_req_capture.sv
module irq_req_capture #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         level_mode,
  input  logic [N-1:0] irq_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);

  logic [N-1:0] prev_q;
  logic [N-1:0] pend_q;

  for (genvar i = 0; i < N; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev_q[i] <= 1'b0;
        pend_q[i] <= 1'b0;
      end else begin
        prev_q[i] <= irq_i[i];
        if (level_mode) begin
          pend_q[i] <= irq_i[i];
        end else if (irq_i[i] && !prev_q[i]) begin
          pend_q[i] <= 1'b1;
        end else if (clr_i[i]) begin
          pend_q[i] <= 1'b0;
        end
      end
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N = 8,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] req_i,
  input  logic [W-1:0] low_i,
  output logic         any_o,
  output logic [W-1:0] idx_o,
  output logic [W-1:0] rank_o
);

  // rot[k] is the request of the line at rank k (rank 0 = highest)
  logic [N-1:0] rot;

  for (genvar k = 0; k < N; k++) begin : g_rank
    logic [W-1:0] pos;
    assign pos    = low_i + W'(k + 1);
    assign rot[k] = req_i[pos];
  end

  always_comb begin
    rank_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (rot[k]) rank_o = W'(k);
    end
    any_o = |rot;
    idx_o = low_i + rank_o + W'(1);
  end

endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_prio_pkg::*;
#(
  parameter int N      = 8,
  parameter int BASE_W = N - MODE_FLAG_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [N-1:0]      wdata_i,
  input  logic [N-1:0]      pend_i,
  input  logic [N-1:0]      isr_i,
  output logic              level_o,
  output logic              aeoi_o,
  output logic              rot_o,
  output logic [BASE_W-1:0] base_o,
  output logic [N-1:0]      mask_o,
  output logic              mode_wr_o,
  output logic              cmd_wr_o,
  output logic [N-1:0]      rdata_o
);

  logic [N-1:0] mode_q;
  logic [N-1:0] mask_q;
  cfg_addr_e    addr;

  assign addr      = cfg_addr_e'(addr_i);
  assign mode_wr_o = we_i && (addr == ADDR_MODE);
  assign cmd_wr_o  = we_i && (addr == ADDR_CMD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      mask_q <= '1;
    end else begin
      if (mode_wr_o) mode_q <= wdata_i;
      if (we_i && addr == ADDR_MASK) mask_q <= wdata_i;
    end
  end

  assign level_o = mode_q[MODE_LEVEL_BIT];
  assign aeoi_o  = mode_q[MODE_AEOI_BIT];
  assign rot_o   = mode_q[MODE_ROT_BIT];
  assign base_o  = mode_q[N-1:MODE_FLAG_BITS];
  assign mask_o  = mask_q;

  always_comb begin
    unique case (addr)
      ADDR_MODE: rdata_o = mode_q;
      ADDR_MASK: rdata_o = mask_q;
      ADDR_CMD:  rdata_o = pend_i;
      ADDR_ISR:  rdata_o = isr_i;
      default:   rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter  int N_LINES = 8,
  localparam int LINE_W  = $clog2(N_LINES),
  localparam int BASE_W  = N_LINES - MODE_FLAG_BITS,
  localparam int VEC_W   = BASE_W + LINE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_i,
  output logic               int_o,
  input  logic               ack_i,
  output logic               vec_valid_o,
  output logic [VEC_W-1:0]   vec_o,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_addr,
  input  logic [N_LINES-1:0] cfg_wdata,
  output logic [N_LINES-1:0] cfg_rdata
);

  logic               level_q, aeoi_q, rot_q;
  logic [BASE_W-1:0]  base_q;
  logic [N_LINES-1:0] mask_q, pend, isr_q, pend_clr;
  logic               mode_wr, eoi_wr;
  logic [LINE_W-1:0]  low_q, low_eff;

  logic               req_any, isr_any;
  logic [LINE_W-1:0]  req_idx, req_rank, isr_idx, isr_rank;
  logic               beats, ack_take, eoi_hit;
  logic [N_LINES-1:0] isr_set, isr_clr;
  logic               vec_valid_q;
  logic [VEC_W-1:0]   vec_q;

  irq_cfg_regs #(.N(N_LINES), .BASE_W(BASE_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_i     (cfg_we),
    .addr_i   (cfg_addr),
    .wdata_i  (cfg_wdata),
    .pend_i   (pend),
    .isr_i    (isr_q),
    .level_o  (level_q),
    .aeoi_o   (aeoi_q),
    .rot_o    (rot_q),
    .base_o   (base_q),
    .mask_o   (mask_q),
    .mode_wr_o(mode_wr),
    .cmd_wr_o (eoi_wr),
    .rdata_o  (cfg_rdata)
  );

  irq_req_capture #(.N(N_LINES)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .level_mode(level_q),
    .irq_i     (irq_i),
    .clr_i     (pend_clr),
    .pend_o    (pend)
  );

  // Lowest-priority line: rotation pointer, or the last line when fixed
  assign low_eff = rot_q ? low_q : '1;

  irq_prio_pick #(.N(N_LINES), .W(LINE_W)) u_pick_req (
    .req_i (pend & ~mask_q),
    .low_i (low_eff),
    .any_o (req_any),
    .idx_o (req_idx),
    .rank_o(req_rank)
  );

  irq_prio_pick #(.N(N_LINES), .W(LINE_W)) u_pick_isr (
    .req_i (isr_q),
    .low_i (low_eff),
    .any_o (isr_any),
    .idx_o (isr_idx),
    .rank_o(isr_rank)
  );

  assign beats    = req_any && (!isr_any || (req_rank < isr_rank));
  assign int_o    = beats;
  assign ack_take = ack_i && beats;
  assign eoi_hit  = eoi_wr && isr_any;

  assign pend_clr = ack_take ? (N_LINES'(1) << req_idx) : '0;
  assign isr_set  = (ack_take && !aeoi_q) ? (N_LINES'(1) << req_idx) : '0;
  assign isr_clr  = eoi_hit ? (N_LINES'(1) << isr_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr_q <= '0;
    end else begin
      isr_q <= (isr_q & ~isr_clr) | isr_set;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_q <= '1;
    end else if (mode_wr) begin
      low_q <= '1;
    end else if (rot_q) begin
      if (ack_take && aeoi_q) low_q <= req_idx;
      else if (eoi_hit)       low_q <= isr_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_valid_q <= 1'b0;
      vec_q       <= '0;
    end else begin
      vec_valid_q <= ack_i;
      if (ack_i) vec_q <= {base_q, (ack_take ? req_idx : {LINE_W{1'b1}})};
    end
  end

  assign vec_valid_o = vec_valid_q;
  assign vec_o       = vec_q;

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int N     = 8,
  parameter int LW    = 3,
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack_i,
  input logic             int_o,
  input logic             vec_valid_o,
  input logic [VEC_W-1:0] vec_o,
  input logic [N-1:0]     mask,
  input logic [N-1:0]     isr,
  input logic             aeoi,
  input logic             eoi
);

  p_vec_follows_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> vec_valid_o);

  p_no_vec_without_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_i |=> !vec_valid_o);

  p_isr_grows_only_on_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_i |=> ((isr & ~$past(isr)) == '0));

  p_single_isr_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> $onehot0(isr & ~$past(isr)));

  p_masked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> !int_o);

  p_spurious_vector_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !int_o && !eoi) |=> ((vec_o[LW-1:0] == {LW{1'b1}}) && $stable(isr)));

  p_auto_eoi_isr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && aeoi && !eoi) |=> $stable(isr));

  p_eoi_drops_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !ack_i && (isr != '0)) |=> ($countones(isr) == $countones($past(isr)) - 1));

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.N(N_LINES), .LW(LINE_W), .VEC_W(VEC_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .ack_i      (ack_i),
  .int_o      (int_o),
  .vec_valid_o(vec_valid_o),
  .vec_o      (vec_o),
  .mask       (mask_q),
  .isr        (isr_q),
  .aeoi       (aeoi_q),
  .eoi        (eoi_wr)
);

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] BASE_BITS = 8'h90;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq = '0;
  logic       int_o, ack = 1'b0, vec_valid;
  logic [7:0] vec;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0, cfg_rdata;

  int checks = 0;
  int fails  = 0;

  irq_prio_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .int_o(int_o), .ack_i(ack),
    .vec_valid_o(vec_valid), .vec_o(vec), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_pend, m_isr, m_mask, m_prev, m_vec;
  logic       m_level, m_aeoi, m_rot, m_vvalid;
  logic [4:0] m_base;
  int         m_low;

  function automatic int eff_low();
    return m_rot ? m_low : 7;
  endfunction

  function automatic int best(logic [7:0] v);
    for (int k = 1; k <= 8; k++) begin
      if (v[(eff_low() + k) % 8]) return (eff_low() + k) % 8;
    end
    return -1;
  endfunction

  function automatic int rank_of(int line);
    return (line - eff_low() - 1 + 16) % 8;
  endfunction

  function automatic bit m_int();
    int r, s;
    r = best(m_pend & ~m_mask);
    s = best(m_isr);
    if (r < 0) return 1'b0;
    return (s < 0) || (rank_of(r) < rank_of(s));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = '0; m_isr = '0; m_mask = '1; m_prev = '0; m_vec = '0;
      m_level = 0; m_aeoi = 0; m_rot = 0; m_vvalid = 0; m_base = '0; m_low = 7;
    end else begin
      automatic int w = m_int() ? best(m_pend & ~m_mask) : -1;
      automatic int e = best(m_isr);
      automatic logic [7:0] n_isr = m_isr;
      automatic int n_low = m_low;
      automatic logic [7:0] rise = irq & ~m_prev;
      if (cfg_we && cfg_addr == 2'd2 && e >= 0) begin
        n_isr[e] = 1'b0;
        if (m_rot) n_low = e;
      end
      m_vvalid = ack;
      if (ack) begin
        if (w >= 0) begin
          m_vec = {m_base, 3'(w)};
          if (m_aeoi) begin
            if (m_rot) n_low = w;
          end else begin
            n_isr[w] = 1'b1;
          end
        end else begin
          m_vec = {m_base, 3'b111};
        end
      end
      if (m_level) m_pend = irq;
      else m_pend = (m_pend & ~((ack && w >= 0) ? (8'd1 << w) : 8'd0)) | rise;
      m_prev = irq;
      if (cfg_we && cfg_addr == 2'd0) begin
        m_level = cfg_wdata[0]; m_aeoi = cfg_wdata[1]; m_rot = cfg_wdata[2];
        m_base = cfg_wdata[7:3]; n_low = 7;
      end
      if (cfg_we && cfg_addr == 2'd1) m_mask = cfg_wdata;
      m_isr = n_isr;
      m_low = n_low;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Compare outputs against the model every cycle, away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(int_o == m_int(), "R5", "int_o vs model", int'(int_o), int'(m_int()));
      chk(vec_valid == m_vvalid, "R6", "vec_valid vs model", int'(vec_valid), int'(m_vvalid));
      if (vec_valid && m_vvalid)
        chk(vec == m_vec, "R6/R11", "vector vs model", int'(vec), int'(m_vec));
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic wr(logic [1:0] a, logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [7:0] exp, string req);
    cfg_addr = a;
    #1;
    chk(cfg_rdata == exp, req, $sformatf("read addr %0d", a), int'(cfg_rdata), int'(exp));
  endtask

  task automatic pulse(logic [7:0] m);
    irq = irq | m;
    @(negedge clk);
    irq = irq & ~m;
  endtask

  task automatic ack_expect(int line, string req);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    #1;
    chk(vec_valid && vec == (BASE_BITS | 8'(line)), req, "acknowledge vector",
        int'(vec), int'(BASE_BITS | 8'(line)));
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(int_o == 1'b0, "R1", "int_o after reset", int'(int_o), 0);
    chk(vec_valid == 1'b0, "R1", "vec_valid after reset", int'(vec_valid), 0);
    rd(2'd0, 8'h00, "R1"); rd(2'd1, 8'hFF, "R1");
    rd(2'd2, 8'h00, "R1"); rd(2'd3, 8'h00, "R1");

    wr(2'd1, 8'h00);
    wr(2'd0, 8'h90);                          // edge, fixed, base 0x12
    // R2 edge capture held after line drops
    pulse(8'h08);
    rd(2'd2, 8'h08, "R2");
    repeat (2) @(negedge clk);
    rd(2'd2, 8'h08, "R2");
    chk(int_o == 1'b1, "R5", "int_o for pending line 3", int'(int_o), 1);
    ack_expect(3, "R6");
    rd(2'd3, 8'h08, "R6"); rd(2'd2, 8'h00, "R6");
    // R5 nesting: lower line blocked, higher line preempts
    pulse(8'h20);
    chk(int_o == 1'b0, "R5", "line 5 blocked by line 3", int'(int_o), 0);
    rd(2'd2, 8'h20, "R5");
    pulse(8'h02);
    chk(int_o == 1'b1, "R5", "line 1 preempts line 3", int'(int_o), 1);
    ack_expect(1, "R6");
    rd(2'd3, 8'h0A, "R6");
    // R8 non-specific end of interrupt
    wr(2'd2, 8'h00);
    rd(2'd3, 8'h08, "R8");
    wr(2'd2, 8'h00);
    rd(2'd3, 8'h00, "R8");
    ack_expect(5, "R6");
    wr(2'd2, 8'h00);
    // R7 fixed order
    pulse(8'h44);
    ack_expect(2, "R7");
    wr(2'd2, 8'h00);
    ack_expect(6, "R7");
    wr(2'd2, 8'h00);
    // R4 masking
    wr(2'd1, 8'h10);
    pulse(8'h10);
    @(negedge clk);
    chk(int_o == 1'b0, "R4", "masked line quiet", int'(int_o), 0);
    rd(2'd2, 8'h10, "R4");
    wr(2'd1, 8'h00);
    chk(int_o == 1'b1, "R4", "unmasked line raises", int'(int_o), 1);
    ack_expect(4, "R4");
    wr(2'd2, 8'h00);
    // R11 spurious with nothing pending
    ack_expect(7, "R11");
    rd(2'd3, 8'h00, "R11");
    // R11 spurious in level mode: request removed before acknowledge
    wr(2'd0, 8'h91);
    irq = 8'h01;
    @(negedge clk);
    chk(int_o == 1'b1, "R11", "int_o for level line 0", int'(int_o), 1);
    irq = 8'h00;
    @(negedge clk);
    ack_expect(7, "R11");
    rd(2'd3, 8'h00, "R11"); rd(2'd2, 8'h00, "R11");
    // R3 level follows with one cycle latency
    irq = 8'h04;
    rd(2'd2, 8'h00, "R3");
    @(negedge clk);
    rd(2'd2, 8'h04, "R3");
    irq = 8'h00;
    @(negedge clk);
    rd(2'd2, 8'h00, "R3");
    // R9 automatic end of interrupt
    wr(2'd0, 8'h92);
    pulse(8'h08);
    ack_expect(3, "R9");
    rd(2'd3, 8'h00, "R9");
    // R10 rotating with command end of interrupt
    wr(2'd0, 8'h94);
    pulse(8'h04);
    ack_expect(2, "R10");
    wr(2'd2, 8'h00);
    pulse(8'h0A);
    ack_expect(3, "R10");
    wr(2'd2, 8'h00);
    ack_expect(1, "R10");
    wr(2'd2, 8'h00);
    // R10 rotating with automatic end of interrupt
    wr(2'd0, 8'h96);
    pulse(8'h01);
    ack_expect(0, "R10");
    pulse(8'h41);
    ack_expect(6, "R10");
    ack_expect(0, "R10");
    // R12 register map and ignored write
    wr(2'd3, 8'hFF);
    rd(2'd3, 8'h00, "R12");
    rd(2'd0, 8'h96, "R12");
    rd(2'd1, 8'h00, "R12");
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule